// File: doc/BRIEF.md
# Stereo Route Selector and Source Mixer

This block is the digital crossbar between the sample interfaces of an audio codec and its converters. Four signed stereo sources arrive together under one valid strobe: the first slot of the primary serial interface, a second slot of that interface, a secondary serial interface and the ADC. Before any mixing, the primary-slot pair passes through a per-channel route selector. Each output side of the selector can keep its own channel, take the other channel, or fold the pair to mono as a saturated sum or as a halved average.

Four mixers then each add any subset of four sources, chosen by enable bits, at extended width. Each result is clamped to the signed sample range. Two mixers feed the DAC pair. The other two feed the capture pair, and each capture mixer can also take the secondary interface's opposite channel. Each of the four outputs has its own enable and reads zero when it is off. Results are registered once, with a valid strobe that trails the input strobe by one cycle.

Two control words configure the block. The route word sets the two selector modes and the four output enables. The mix word holds one 4-bit source-enable nibble for each of the four mixers.

Top module: `stereo_route_mixer`

## Requirements
- R1: The left selector mode is `route_cfg[11:10]` and the right selector mode is `route_cfg[9:8]`. Mode 0 (stereo) passes each side its own channel of the primary slot.
- R2: Mode 1 (swap) gives the left side the right input and the right side the left input.
- R3: Mode 2 (sum mono) gives a side the sum L+R, clamped to [-32768, 32767].
- R4: Mode 3 (average mono) gives a side (L+R) shifted right by one with sign fill, so an odd negative sum rounds toward minus infinity.
- R5: The DAC-left mixer uses enables `mix_cfg[15:12]` and the DAC-right mixer uses `mix_cfg[11:8]`. Within each nibble, from the high bit to the low bit, the sources are: the routed primary slot, the second slot, the secondary interface and the ADC, each on the same side. The enabled sources are added.
- R6: The capture-left mixer uses enables `mix_cfg[7:4]` and the capture-right mixer uses `mix_cfg[3:0]`. Within each nibble, from the high bit to the low bit, the sources are: the routed primary slot (same side), the secondary interface (same side), the ADC (same side) and the secondary interface's opposite side.
- R7: A mixer sum is clamped to [-32768, 32767].
- R8: A mixer with no enabled source produces zero.
- R9: Output enables are `route_cfg[15]` for DAC left, `[14]` for DAC right, `[13]` for capture left and `[12]` for capture right. A cleared enable forces that output to zero.
- R10: Outputs reflect the inputs and controls sampled on the cycle `in_valid` was high, one clock later. `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low the sample outputs hold.
- R11: During reset all sample outputs are zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | All source samples valid this cycle |
| if1s0_l | input | 16 | Primary interface slot 0, left |
| if1s0_r | input | 16 | Primary interface slot 0, right |
| if1s1_l | input | 16 | Primary interface slot 1, left |
| if1s1_r | input | 16 | Primary interface slot 1, right |
| if2_l | input | 16 | Secondary interface, left |
| if2_r | input | 16 | Secondary interface, right |
| adc_l | input | 16 | ADC path, left |
| adc_r | input | 16 | ADC path, right |
| route_cfg | input | 8 (bits 15:8) | Output enables and selector modes |
| mix_cfg | input | 16 | Source-enable nibbles of the four mixers |
| out_valid | output | 1 | Output samples updated this cycle |
| dac_l | output | 16 | DAC left sample |
| dac_r | output | 16 | DAC right sample |
| cap_l | output | 16 | Capture left sample |
| cap_r | output | 16 | Capture right sample |

## Verification
On every cycle the assertions check the timing and gating rules. They check that the valid strobe trails its input by one clock, that the outputs hold while no sample is offered, and that a disabled output or an empty mixer reads zero. They also cover three single-source paths: stereo pass-through, swap, and the crossed capture feed. The arithmetic cases need the bench's scenarios: the clamped mono sum, the floor behaviour of the average, the clamp on a four-source mixer sum, and mixed modes on the two sides. These are compared against the bench's integer model.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int MIX_SRCS  = 4;
    localparam int MIX_PATHS = 4;

    typedef enum logic [1:0] {
        ROUTE_STEREO = 2'd0,
        ROUTE_SWAP   = 2'd1,
        ROUTE_SUM    = 2'd2,
        ROUTE_AVG    = 2'd3
    } route_mode_e;

    // route word bit positions
    localparam int RT_EN_DAC_L = 15;
    localparam int RT_EN_DAC_R = 14;
    localparam int RT_EN_CAP_L = 13;
    localparam int RT_EN_CAP_R = 12;
    localparam int RT_MODE_L   = 10;
    localparam int RT_MODE_R   = 8;

    // mixer path indices
    localparam int PATH_DAC_L = 0;
    localparam int PATH_DAC_R = 1;
    localparam int PATH_CAP_L = 2;
    localparam int PATH_CAP_R = 3;

endpackage

// File: rtl/srm_route_sel.sv
module srm_route_sel
    import srm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   mode_l_i,
    input  logic [1:0]   mode_r_i,
    input  logic [W-1:0] in_l_i,
    input  logic [W-1:0] in_r_i,
    output logic [W-1:0] out_l_o,
    output logic [W-1:0] out_r_o
);

    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]          pair_sum;
    logic [W-1:0]        sum_sat;
    logic [W-1:0]        pair_avg;
    logic [1:0][1:0]     mode;
    logic [1:0][W-1:0]   own;
    logic [1:0][W-1:0]   oth;
    logic [1:0][W-1:0]   pick;

    always_comb begin
        // one shared adder serves both mono modes on both sides
        pair_sum = {in_l_i[W-1], in_l_i} + {in_r_i[W-1], in_r_i};
        if (pair_sum[W] != pair_sum[W-1]) begin
            sum_sat = pair_sum[W] ? S_MIN : S_MAX;
        end else begin
            sum_sat = pair_sum[W-1:0];
        end
        pair_avg = pair_sum[W:1];

        mode = {mode_r_i, mode_l_i};
        own  = {in_r_i, in_l_i};
        oth  = {in_l_i, in_r_i};

        for (int ch = 0; ch < 2; ch++) begin
            unique case (route_mode_e'(mode[ch]))
                ROUTE_STEREO: pick[ch] = own[ch];
                ROUTE_SWAP:   pick[ch] = oth[ch];
                ROUTE_SUM:    pick[ch] = sum_sat;
                ROUTE_AVG:    pick[ch] = pair_avg;
            endcase
        end
    end

    assign out_l_o = pick[0];
    assign out_r_o = pick[1];

endmodule

// File: rtl/srm_src_mixer.sv
module srm_src_mixer #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic [N-1:0][W-1:0] src_i,
    input  logic [N-1:0]        en_i,
    output logic [W-1:0]        mix_o
);

    localparam int EXT_W = W + $clog2(N);
    localparam logic signed [EXT_W-1:0] E_MAX = {{(EXT_W-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] E_MIN = {{(EXT_W-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [N-1:0][EXT_W-1:0] term;
    logic signed [EXT_W-1:0]        acc;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_term
            assign term[i] = en_i[i] ? {{(EXT_W-W){src_i[i][W-1]}}, src_i[i]} : '0;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            acc = acc + $signed(term[k]);
        end
        if (acc > E_MAX) begin
            mix_o = {1'b0, {(W-1){1'b1}}};
        end else if (acc < E_MIN) begin
            mix_o = {1'b1, {(W-1){1'b0}}};
        end else begin
            mix_o = acc[W-1:0];
        end
    end

endmodule

// File: rtl/stereo_route_mixer.sv
module stereo_route_mixer
    import srm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] if1s0_l,
    input  logic signed [W-1:0] if1s0_r,
    input  logic signed [W-1:0] if1s1_l,
    input  logic signed [W-1:0] if1s1_r,
    input  logic signed [W-1:0] if2_l,
    input  logic signed [W-1:0] if2_r,
    input  logic signed [W-1:0] adc_l,
    input  logic signed [W-1:0] adc_r,
    input  logic [15:8]         route_cfg,
    input  logic [15:0]         mix_cfg,
    output logic                out_valid,
    output logic signed [W-1:0] dac_l,
    output logic signed [W-1:0] dac_r,
    output logic signed [W-1:0] cap_l,
    output logic signed [W-1:0] cap_r
);

    localparam int EN_TOP = RT_EN_DAC_L;

    typedef struct packed {
        logic                          vld;
        logic [MIX_PATHS-1:0][W-1:0]   smp;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] rt_l, rt_r;
    logic [MIX_PATHS-1:0][MIX_SRCS-1:0][W-1:0] mix_src;
    logic [MIX_PATHS-1:0][W-1:0]               mix_out;

    srm_route_sel #(.W(W)) u_route (
        .mode_l_i (route_cfg[RT_MODE_L +: 2]),
        .mode_r_i (route_cfg[RT_MODE_R +: 2]),
        .in_l_i   (if1s0_l),
        .in_r_i   (if1s0_r),
        .out_l_o  (rt_l),
        .out_r_o  (rt_r)
    );

    // source order per nibble: index 3 is the high enable bit
    always_comb begin
        mix_src[PATH_DAC_L] = {rt_l, if1s1_l, if2_l, adc_l};
        mix_src[PATH_DAC_R] = {rt_r, if1s1_r, if2_r, adc_r};
        mix_src[PATH_CAP_L] = {rt_l, if2_l, adc_l, if2_r};
        mix_src[PATH_CAP_R] = {rt_r, if2_r, adc_r, if2_l};
    end

    genvar g;
    generate
        for (g = 0; g < MIX_PATHS; g++) begin : g_mix
            srm_src_mixer #(.W(W), .N(MIX_SRCS)) u_mix (
                .src_i (mix_src[g]),
                .en_i  (mix_cfg[MIX_SRCS*(MIX_PATHS-1-g) +: MIX_SRCS]),
                .mix_o (mix_out[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            for (int p = 0; p < MIX_PATHS; p++) begin
                st_d.smp[p] = route_cfg[EN_TOP - p] ? mix_out[p] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign dac_l     = st_q.smp[PATH_DAC_L];
    assign dac_r     = st_q.smp[PATH_DAC_R];
    assign cap_l     = st_q.smp[PATH_CAP_L];
    assign cap_r     = st_q.smp[PATH_CAP_R];

    // ---------------- assertions ----------------
    assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dac_l) && $stable(dac_r) && $stable(cap_l) && $stable(cap_r)));

    assert_dac_l_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !route_cfg[RT_EN_DAC_L]) |=> (dac_l == '0));

    assert_cap_r_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !route_cfg[RT_EN_CAP_R]) |=> (cap_r == '0));

    assert_empty_mix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_cfg[15:12] == 4'b0000) |=> (dac_l == '0));

    assert_stereo_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[RT_EN_DAC_L] && route_cfg[11:10] == 2'd0 && mix_cfg[15:12] == 4'b1000)
        |=> (dac_l == $past(if1s0_l)));

    assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[RT_EN_DAC_R] && route_cfg[9:8] == 2'd1 && mix_cfg[11:8] == 4'b1000)
        |=> (dac_r == $past(if1s0_l)));

    assert_cross_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[RT_EN_CAP_L] && mix_cfg[7:4] == 4'b0001)
        |=> (cap_l == $past(if2_r)));

endmodule

// File: tb/sim_stereo_route_mixer.sv
`timescale 1ns/1ps
module sim_stereo_route_mixer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] if1s0_l = '0, if1s0_r = '0, if1s1_l = '0, if1s1_r = '0;
    logic signed [15:0] if2_l = '0, if2_r = '0, adc_l = '0, adc_r = '0;
    logic [15:8] route_cfg = '0;
    logic [15:0] mix_cfg = '0;
    logic out_valid;
    logic signed [15:0] dac_l, dac_r, cap_l, cap_r;

    int n_cmp = 0;
    int n_bad = 0;
    int e_vld = 0, e_dl = 0, e_dr = 0, e_cl = 0, e_cr = 0;

    always #2 clk = ~clk;

    stereo_route_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .if1s0_l(if1s0_l), .if1s0_r(if1s0_r), .if1s1_l(if1s1_l), .if1s1_r(if1s1_r),
        .if2_l(if2_l), .if2_r(if2_r), .adc_l(adc_l), .adc_r(adc_r),
        .route_cfg(route_cfg), .mix_cfg(mix_cfg),
        .out_valid(out_valid), .dac_l(dac_l), .dac_r(dac_r), .cap_l(cap_l), .cap_r(cap_r)
    );

    function automatic int clamp16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int route_pick(int mode, int own, int oth);
        case (mode)
            0: return own;
            1: return oth;
            2: return clamp16(own + oth);
            default: return (own + oth) >>> 1;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic drive(int a, int b, int c, int d, int e, int f, int g, int h);
        if1s0_l = 16'(a); if1s0_r = 16'(b); if1s1_l = 16'(c); if1s1_r = 16'(d);
        if2_l = 16'(e); if2_r = 16'(f); adc_l = 16'(g); adc_r = 16'(h);
    endtask

    // called at a negedge with inputs settled; compares one clock later
    task automatic cycle(string tag);
        int l0, r0, rl, rr, sdl, sdr, scl, scr;
        l0 = int'(if1s0_l); r0 = int'(if1s0_r);
        rl = route_pick(int'(route_cfg[11:10]), l0, r0);
        rr = route_pick(int'(route_cfg[9:8]), r0, l0);
        sdl = (mix_cfg[15] ? rl : 0) + (mix_cfg[14] ? int'(if1s1_l) : 0)
            + (mix_cfg[13] ? int'(if2_l) : 0) + (mix_cfg[12] ? int'(adc_l) : 0);
        sdr = (mix_cfg[11] ? rr : 0) + (mix_cfg[10] ? int'(if1s1_r) : 0)
            + (mix_cfg[9] ? int'(if2_r) : 0) + (mix_cfg[8] ? int'(adc_r) : 0);
        scl = (mix_cfg[7] ? rl : 0) + (mix_cfg[6] ? int'(if2_l) : 0)
            + (mix_cfg[5] ? int'(adc_l) : 0) + (mix_cfg[4] ? int'(if2_r) : 0);
        scr = (mix_cfg[3] ? rr : 0) + (mix_cfg[2] ? int'(if2_r) : 0)
            + (mix_cfg[1] ? int'(adc_r) : 0) + (mix_cfg[0] ? int'(if2_l) : 0);
        e_vld = int'(in_valid);
        if (in_valid) begin
            e_dl = route_cfg[15] ? clamp16(sdl) : 0;
            e_dr = route_cfg[14] ? clamp16(sdr) : 0;
            e_cl = route_cfg[13] ? clamp16(scl) : 0;
            e_cr = route_cfg[12] ? clamp16(scr) : 0;
        end
        @(posedge clk);
        #1;
        check(tag, "out_valid", int'(out_valid), e_vld);
        check(tag, "dac_l", int'(dac_l), e_dl);
        check(tag, "dac_r", int'(dac_r), e_dr);
        check(tag, "cap_l", int'(cap_l), e_cl);
        check(tag, "cap_r", int'(cap_r), e_cr);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        drive(1234, -77, 5, 6, 7, 8, 9, 10);
        in_valid = 1'b1;
        route_cfg = 8'hF0;
        mix_cfg = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R11: reset holds everything at zero even with valid input
        check("R11", "out_valid", int'(out_valid), 0);
        check("R11", "dac_l", int'(dac_l), 0);
        check("R11", "dac_r", int'(dac_r), 0);
        check("R11", "cap_l", int'(cap_l), 0);
        check("R11", "cap_r", int'(cap_r), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        cycle("R11");

        // R1 stereo pass, routed-only mixers
        in_valid = 1'b1;
        route_cfg = 8'hF0; mix_cfg = 16'h8888;
        drive(1000, -2000, 0, 0, 0, 0, 0, 0); cycle("R1");
        drive(-32768, 32767, 1, 1, 1, 1, 1, 1); cycle("R1");
        // R2 swap both sides
        route_cfg = 8'hF5;
        drive(321, -654, 0, 0, 0, 0, 0, 0); cycle("R2");
        // R3 sum mono, saturating both ways
        route_cfg = 8'hFA;
        drive(100, 250, 0, 0, 0, 0, 0, 0); cycle("R3");
        drive(30000, 10000, 0, 0, 0, 0, 0, 0); cycle("R3");
        drive(-30000, -10000, 0, 0, 0, 0, 0, 0); cycle("R3");
        // R4 average mono, floor on odd negative
        route_cfg = 8'hFF;
        drive(-3, 0, 0, 0, 0, 0, 0, 0); cycle("R4");
        drive(32767, 32767, 0, 0, 0, 0, 0, 0); cycle("R4");
        drive(-32768, -32767, 0, 0, 0, 0, 0, 0); cycle("R4");
        // mixed modes: left sum, right average
        route_cfg = 8'hFB;
        drive(20001, 20000, 0, 0, 0, 0, 0, 0); cycle("R3");
        route_cfg = 8'hF7;
        drive(7, -10, 0, 0, 0, 0, 0, 0); cycle("R4");
        // R5 playback sources one at a time, then all
        route_cfg = 8'hF0;
        drive(11, 12, 21, 22, 31, 32, 41, 42);
        for (int b = 0; b < 4; b++) begin
            mix_cfg = 16'(16'h1100 << b);
            cycle("R5");
        end
        mix_cfg = 16'hFF00; cycle("R5");
        // R6 capture sources one at a time, including the crossed feed
        for (int b = 0; b < 4; b++) begin
            mix_cfg = 16'(16'h0011 << b);
            cycle("R6");
        end
        mix_cfg = 16'h00FF; cycle("R6");
        // R7 mixer clamp
        mix_cfg = 16'hFFFF;
        drive(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767); cycle("R7");
        drive(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768); cycle("R7");
        drive(30000, -30000, 5000, -5000, -1, 1, 0, 0); cycle("R7");
        // R8 empty mixers
        mix_cfg = 16'h0000;
        drive(500, 600, 700, 800, 900, 1000, 1100, 1200); cycle("R8");
        mix_cfg = 16'h0F0F; cycle("R8");
        // R9 output enables one at a time off
        mix_cfg = 16'hFFFF;
        for (int b = 0; b < 4; b++) begin
            route_cfg = 8'hF0 ^ 8'(8'h80 >> b);
            cycle("R9");
        end
        route_cfg = 8'h00; cycle("R9");
        // R10 hold while idle, with new data and controls present
        route_cfg = 8'hF0;
        drive(1, 2, 3, 4, 5, 6, 7, 8); cycle("R10");
        in_valid = 1'b0;
        drive(-9, -9, -9, -9, -9, -9, -9, -9); mix_cfg = 16'h1111; cycle("R10");
        cycle("R10");
        in_valid = 1'b1; cycle("R10");

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            in_valid = ($urandom_range(0, 3) != 0);
            route_cfg = 8'($urandom);
            if ($urandom_range(0, 1) == 0) route_cfg[15:12] = 4'hF;
            mix_cfg = 16'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                drive(32767, -32768, 32767, -32768, 32767, 32767, -32768, -32768);
            end else begin
                drive(int'(16'($urandom)), int'(16'($urandom)), int'(16'($urandom)), int'(16'($urandom)),
                      int'(16'($urandom)), int'(16'($urandom)), int'(16'($urandom)), int'(16'($urandom)));
                if1s0_l = 16'($urandom); if1s0_r = 16'($urandom);
            end
            cycle("R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule